// File: doc/BRIEF.md
# Configurable Interrupt Output Combiner

This block turns the pending-event vectors of two functions of a USB controller, a host-side function and a device-side function, into interrupt request pins. Each function gets its own pin, its own enable, its own output polarity and its own trigger mode. In level mode a pin stays asserted while any event is pending. In edge mode a pin emits one pulse of a fixed number of clock cycles and then returns to its inactive level. A merge mode routes both requests onto the first pin, so a system with only one spare CPU interrupt input can serve both functions. In that mode the second pin is held quiet.

A pulse can fire while the CPU has interrupts masked, and the CPU would then miss it. For that reason the block keeps a sticky record of each function's request arrivals, which software reads and clears by writing 1 to it. Event vectors arrive already masked. Configuration comes through a simple write port with a 2-bit address.

Top module: `irq_pin_combiner`

## Requirements
- R1: After reset, every enable, the merge bit and both trigger bits are 0. Both polarities are active-low, so both pins sit at 1, and `sticky_o` is 0.
- R2: In level mode (trigger bit 1 = 0), a pin is active from one cycle after any enabled event bit is pending until one cycle after all of them clear.
- R3: In edge mode (trigger bit 1 = 1), a 0-to-1 change of a pin's enabled request makes the pin active for exactly PULSE_W cycles, starting one cycle later. The pin then goes inactive even if the events stay pending.
- R4: Configuration bit 0 is the polarity: 1 = active-high, 0 = active-low. Register addresses are 0 for the host config, 1 for the device config, 2 for the device mode and 3 for the status clear. A new polarity takes effect on the pin in the cycle after the write.
- R5: Host config bit 2 is the host enable. While it is 0, host events drive nothing and set no sticky bit.
- R6: Device mode register bit 3 is the device enable. While it is 0, device events drive nothing and set no sticky bit.
- R7: When host config bit 9 (merge) is 1, `int1_o` carries the OR of both enabled requests, shaped by the host polarity and trigger. `int2_o` is held at the device's inactive level.
- R8: In edge mode, a new 0-to-1 change of either merged request during a pulse restarts the full PULSE_W width.
- R9: `sticky_o` bit 0 (host) and bit 1 (device) are set on each 0-to-1 change of that function's enabled request, in any mode. Writing 1 to a bit at address 3 clears it.
- R10: When a set and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_evt_i | input | HOST_W | Pending, pre-masked host-side events |
| dev_evt_i | input | DEV_W | Pending, pre-masked device-side events |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register address (0 host cfg, 1 device cfg, 2 device mode, 3 status clear) |
| cfg_wdata_i | input | CFG_DW | Write data |
| int1_o | output | 1 | First interrupt pin (host, or merged) |
| int2_o | output | 1 | Second interrupt pin (device) |
| sticky_o | output | 2 | Sticky arrival record: bit 0 host, bit 1 device |

## Verification
Every result of this block is due one clock edge after the edge that samples its cause. A pending event shows on a pin and in the sticky bits after that edge. A write changes the idle level, the clear and the routing after its own edge, so any request it unblocks reaches the pin one edge later. An edge-mode pulse covers the PULSE_W edges that follow its trigger edge. The driver pushes, at each edge, the expected pin levels and sticky bits for the outputs that edge produces. The monitor pops and compares them 2 ns after that same edge, well away from the next one. Inputs change 1 ns after an edge, and the pins depend only on registers, so no check depends on the order of processes at an edge.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  localparam logic [1:0] ADDR_HOST_CFG = 2'd0;
  localparam logic [1:0] ADDR_DEV_CFG  = 2'd1;
  localparam logic [1:0] ADDR_DEV_MODE = 2'd2;
  localparam logic [1:0] ADDR_STATUS   = 2'd3;

  localparam int BIT_POL     = 0;
  localparam int BIT_TRIG    = 1;
  localparam int BIT_HOST_EN = 2;
  localparam int BIT_DEV_EN  = 3;
  localparam int BIT_MERGE   = 9;

  localparam int N_SRC = 2;
  localparam int N_PIN = 2;

  typedef struct packed {
    logic merge;
    logic host_en;
    logic host_edge;
    logic host_pol;
    logic dev_en;
    logic dev_edge;
    logic dev_pol;
  } irq_cfg_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_comb_pkg::*;
#(
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output irq_cfg_t          cfg_o,
  output logic [N_SRC-1:0]  clr_o
);

  irq_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_HOST_CFG: begin
          cfg_q.host_pol  <= wdata_i[BIT_POL];
          cfg_q.host_edge <= wdata_i[BIT_TRIG];
          cfg_q.host_en   <= wdata_i[BIT_HOST_EN];
          cfg_q.merge     <= wdata_i[BIT_MERGE];
        end
        ADDR_DEV_CFG: begin
          cfg_q.dev_pol  <= wdata_i[BIT_POL];
          cfg_q.dev_edge <= wdata_i[BIT_TRIG];
        end
        ADDR_DEV_MODE: cfg_q.dev_en <= wdata_i[BIT_DEV_EN];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign clr_o = (we_i && addr_i == ADDR_STATUS) ? wdata_i[N_SRC-1:0] : '0;

  logic unused_bits;
  assign unused_bits = ^wdata_i;

endmodule

// File: rtl/irq_sticky.sv
module irq_sticky
  import irq_comb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] sticky_o
);

  logic [N_SRC-1:0] req_q, sticky_q, set;

  assign set = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      sticky_q <= '0;
    end else begin
      req_q    <= req_i;
      sticky_q <= (sticky_q & ~clr_i) | set;
    end
  end

  assign sticky_o = sticky_q;

  // R10: an arrival is never lost to a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set) |=> ((sticky_q & $past(set)) == $past(set)));

  // R9: a clear with no arrival empties the bit
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set)) |=> ((sticky_q & $past(clr_i & ~set)) == '0));

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper #(
  parameter int N_REQ   = 2,
  parameter int PULSE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             edge_mode_i,
  input  logic             active_high_i,
  input  logic             hold_off_i,
  output logic             pin_o
);

  localparam int CNT_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W);

  logic [N_REQ-1:0] req_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             rise, act;

  // any source rising re-arms the pulse (extension, not glitch)
  assign rise = |(req_i & ~req_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      req_q <= req_i;
      lvl_q <= |req_i;
      if (!edge_mode_i)      cnt_q <= '0;
      else if (rise)         cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign act   = edge_mode_i ? (cnt_q != '0) : lvl_q;
  assign pin_o = (act & ~hold_off_i) ^ ~active_high_i;

  // R3: pulse width bounded by PULSE_W
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);

  // R3: a running pulse counts down one per cycle without a new rise
  p_countdown_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && cnt_q != '0 && !rise) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: a rise in edge mode restarts the full width
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && rise) |=> (cnt_q == CNT_LOAD));

endmodule

// File: rtl/irq_pin_combiner.sv
module irq_pin_combiner
  import irq_comb_pkg::*;
#(
  parameter int HOST_W  = 16,
  parameter int DEV_W   = 16,
  parameter int PULSE_W = 8,
  parameter int CFG_DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOST_W-1:0] host_evt_i,
  input  logic [DEV_W-1:0]  dev_evt_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              int1_o,
  output logic              int2_o,
  output logic [N_SRC-1:0]  sticky_o
);

  irq_cfg_t         cfg;
  logic [N_SRC-1:0] clr;
  logic             req_h, req_d;

  irq_cfg_regs #(.CFG_DW(CFG_DW)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg),
    .clr_o  (clr)
  );

  assign req_h = cfg.host_en & (|host_evt_i);
  assign req_d = cfg.dev_en  & (|dev_evt_i);

  irq_sticky i_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   ({req_d, req_h}),
    .clr_i   (clr),
    .sticky_o(sticky_o)
  );

  logic [N_SRC-1:0] pin_req  [N_PIN];
  logic             pin_edge [N_PIN];
  logic             pin_pol  [N_PIN];
  logic             pin_hold [N_PIN];
  logic [N_PIN-1:0] pin_out;

  always_comb begin
    pin_req[0]  = {cfg.merge & req_d, req_h};
    pin_edge[0] = cfg.host_edge;
    pin_pol[0]  = cfg.host_pol;
    pin_hold[0] = 1'b0;
    pin_req[1]  = {1'b0, ~cfg.merge & req_d};
    pin_edge[1] = cfg.dev_edge;
    pin_pol[1]  = cfg.dev_pol;
    pin_hold[1] = cfg.merge;
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    irq_pin_shaper #(.N_REQ(N_SRC), .PULSE_W(PULSE_W)) i_shaper (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (pin_req[p]),
      .edge_mode_i  (pin_edge[p]),
      .active_high_i(pin_pol[p]),
      .hold_off_i   (pin_hold[p]),
      .pin_o        (pin_out[p])
    );
  end

  assign int1_o = pin_out[0];
  assign int2_o = pin_out[1];

  // R7: second pin silent while merged
  p_int2_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.merge |-> (int2_o == ~cfg.dev_pol));

  // R6: disabled device side in level mode leaves its pin idle
  p_dev_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cfg.dev_en && !cfg.dev_edge && !cfg.merge) && !cfg.dev_edge &&
     !cfg.merge && $stable(cfg.dev_pol)) |-> (int2_o == ~cfg.dev_pol));

endmodule

// File: tb/test_irq_pin_combiner.sv
module test_irq_pin_combiner;

  localparam realtime HALF = 2.5ns;
  localparam int PW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] host_evt = '0;
  logic [15:0] dev_evt = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        int1, int2;
  logic [1:0]  sticky;

  always #HALF clk_i = ~clk_i;

  irq_pin_combiner #(.HOST_W(16), .DEV_W(16), .PULSE_W(PW), .CFG_DW(16)) i_irq_pin_combiner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_evt_i (host_evt),
    .dev_evt_i  (dev_evt),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_wdata_i(cfg_wdata),
    .int1_o     (int1),
    .int2_o     (int2),
    .sticky_o   (sticky)
  );

  typedef struct {
    logic       i1;
    logic       i2;
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_err = 0;
  bit   done  = 0;

  initial begin
    forever begin
      @(posedge clk_i);
      #2ns;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (int1 !== e.i1 || int2 !== e.i2 || sticky !== e.st) begin
          n_err++;
          $display("FAIL %s: int1=%b int2=%b sticky=%b expected int1=%b int2=%b sticky=%b",
                   e.tag, int1, int2, sticky, e.i1, e.i2, e.st);
        end
      end
    end
  end

  task automatic tick(input logic e1, input logic e2, input logic [1:0] es, input string tag);
    exp_t e;
    @(posedge clk_i);
    e.i1 = e1; e.i2 = e2; e.st = es; e.tag = tag;
    q.push_back(e);
    #1ns;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d,
                    input logic e1, input logic e2, input logic [1:0] es, input string tag);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(e1, e2, es, tag);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  initial begin
    #(HALF * 2 * 5000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1ns rst_ni = 1'b1;

    tick(1, 1, 2'b00, "R1 reset idle");

    // R5: host disabled, events ignored
    host_evt = 16'h0010;
    repeat (2) tick(1, 1, 2'b00, "R5 host disabled");
    wr(2'd0, 16'h0004, 1, 1, 2'b00, "R5 enable write edge");

    // R2: level active-low
    repeat (3) tick(0, 1, 2'b01, "R2 level held");
    host_evt = '0;
    tick(1, 1, 2'b01, "R2 level release");
    wr(2'd3, 16'h0001, 1, 1, 2'b00, "R9 write-1 clear");

    // R10: set and clear together
    host_evt = 16'h8000;
    wr(2'd3, 16'h0001, 0, 1, 2'b01, "R10 set beats clear");
    host_evt = '0;
    tick(1, 1, 2'b01, "R10 held");
    wr(2'd3, 16'h0001, 1, 1, 2'b00, "R9 clear again");

    // R4 + R3: edge mode, active-high
    wr(2'd0, 16'h0007, 0, 1, 2'b00, "R4 idle level active-high");
    host_evt = 16'h0001;
    repeat (PW) tick(1, 1, 2'b01, "R3 pulse on");
    repeat (2) tick(0, 1, 2'b01, "R3 pulse ends while pending");
    host_evt = '0;
    tick(0, 1, 2'b01, "R3 idle");
    wr(2'd3, 16'h0001, 0, 1, 2'b00, "R9 clear host");

    // R6: device enable
    dev_evt = 16'h0100;
    tick(0, 1, 2'b00, "R6 device disabled");
    wr(2'd2, 16'h0008, 0, 1, 2'b00, "R6 enable write edge");
    tick(0, 0, 2'b10, "R6 device level active");
    dev_evt = '0;
    tick(0, 1, 2'b10, "R6 device release");
    wr(2'd3, 16'h0002, 0, 1, 2'b00, "R9 clear device");

    // R7 + R8: merged edge mode, extension
    wr(2'd1, 16'h0003, 0, 0, 2'b00, "R4 device active-high idle");
    wr(2'd0, 16'h0207, 0, 0, 2'b00, "R7 merge on");
    dev_evt = 16'h0001;
    tick(1, 0, 2'b10, "R7 device pulse on int1");
    host_evt = 16'h0002;
    repeat (PW) tick(1, 0, 2'b11, "R8 pulse extended");
    tick(0, 0, 2'b11, "R8 extended pulse ends");
    host_evt = '0; dev_evt = '0;
    tick(0, 0, 2'b11, "R8 idle");
    wr(2'd3, 16'h0003, 0, 0, 2'b00, "R9 clear both");

    // R7: merged level mode, active-low
    wr(2'd1, 16'h0000, 0, 1, 2'b00, "R7 int2 forced inactive");
    wr(2'd0, 16'h0204, 1, 1, 2'b00, "R7 merged level idle");
    dev_evt = 16'h0400;
    repeat (2) tick(0, 1, 2'b10, "R7 device on int1 only");
    dev_evt = '0;
    tick(1, 1, 2'b10, "R7 merged release");
    wr(2'd0, 16'h0004, 1, 1, 2'b10, "R7 merge off");
    dev_evt = 16'h0400;
    tick(1, 0, 2'b10, "R7 device back on int2");

    repeat (3) @(posedge clk_i);
    #3ns;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule